// File: doc/BRIEF.md
# Runahead Speculative Store Cache

While a core runs ahead of a long-latency miss, the stores it executes must not reach the data cache or memory. Later speculative loads still need to see the values those stores produced. This block is a small set-associative store cache that holds those speculative store bytes. Runahead loads probe it in the same cycle as the L1 data cache. On a hit, the bytes it holds take precedence over the L1 bytes.

The cache is lossy. A line pushed out to make room is dropped without any writeback. A store whose address is unknown is dropped. Every byte carries a valid-data mark, so a store whose data was itself unknown poisons the bytes it covers, and a load that reads those bytes is told they are unusable. When the core leaves runahead mode, a single flush cycle empties the whole structure.

A byte address splits into three fields. The low log2(LINE_BYTES) bits select the byte within a line. The next log2(SETS) bits select the set. The remaining bits form the tag. A probe presented in cycle N is answered on the outputs in cycle N+1. The answer reflects any store and any flush presented in cycle N.

Top module: `rsc_store_cache`

## Requirements
- R1: A store with `st_valid_i` and `st_addr_ok_i` set writes the bytes whose `st_be_i` bit is set (bit b covers data bits 8b+7..8b) into the line addressed by `st_addr_i`. A later probe of that line returns `ld_hit_o`=1 and those bytes, in the cycle after the probe.
- R2: On a hit, each byte never written since the line was allocated is taken from `l1_data_i` of the probe cycle.
- R3: On a miss, `ld_hit_o`=0, `ld_data_o` equals `l1_data_i` of the probe cycle, and `ld_bad_o` is all zero. In a cycle after no probe, all three outputs are zero.
- R4: A store with `st_addr_ok_i`=0 changes nothing. A later probe of that address misses.
- R5: A store with `st_data_ok_i`=0 still writes its data bytes, but sets their bits in `ld_bad_o` (bit b for byte b) when they are read. A later store with valid data to a byte clears that byte's bit.
- R6: A store that misses in a full set replaces the least recently used way, and the old line's bytes are lost. A store that misses fills an empty way, the lowest-numbered one first, before it evicts anything.
- R7: A load hit, like a store, makes the accessed way the most recently used one in its set.
- R8: `flush_i` empties every line in one cycle and wins over a store in the same cycle. A probe in the flush cycle misses.
- R9: When a store and a probe address the same line in the same cycle, the probe sees the stored bytes.
- R10: After reset all lines are empty and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Runahead exit: discard every line |
| st_valid_i | input | 1 | Speculative store present |
| st_addr_i | input | ADDR_W | Store byte address |
| st_data_i | input | LINE_BYTES*8 | Store data, lane-aligned to the line |
| st_be_i | input | LINE_BYTES | Store byte enables |
| st_addr_ok_i | input | 1 | Store address is known |
| st_data_ok_i | input | 1 | Store data is known |
| ld_valid_i | input | 1 | Load probe present |
| ld_addr_i | input | ADDR_W | Load byte address |
| l1_data_i | input | LINE_BYTES*8 | L1 line data read in parallel with the probe |
| ld_hit_o | output | 1 | Probe hit a resident line |
| ld_data_o | output | LINE_BYTES*8 | Merged load data |
| ld_bad_o | output | LINE_BYTES | Per-byte unknown-data flags |

## Verification
The bench uses the defaults: 32-bit addresses, four sets and eight-byte lines. Addresses 32 bytes apart therefore fall in the same set, and three of them are enough to fill a set and force an eviction within a few cycles. The eviction sequence is ordered so that only a design which refreshes recency on load hits keeps the line touched last. A fourth address, in another set, is used for the same-cycle store and probe case and for byte-lane merging.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int WAYS  = 2;
    localparam int WAY_W = 1;

    typedef logic [WAYS-1:0] way_vec_t;

    // lowest-numbered empty way, if any
    function automatic logic [WAY_W-1:0] pick_free(input way_vec_t used);
        logic [WAY_W-1:0] sel;
        sel = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!used[w]) sel = WAY_W'(w);
        end
        return sel;
    endfunction
endpackage

// File: rtl/rsc_tag_match.sv
module rsc_tag_match
    import rsc_pkg::*;
#(
    parameter int TAG_W = 27
) (
    input  way_vec_t                     vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]   tags_i,
    input  logic [TAG_W-1:0]             req_tag_i,
    output way_vec_t                     hit_vec_o,
    output logic                         hit_o,
    output logic [WAY_W-1:0]             hit_way_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = vld_i[w] && (tags_i[w] == req_tag_i);
    end

    always_comb begin
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
        end
    end

    assign hit_o = |hit_vec_o;
endmodule

// File: rtl/rsc_byte_merge.sv
module rsc_byte_merge #(
    parameter int LINE_BYTES = 8
) (
    input  logic                      hit_i,
    input  logic [LINE_BYTES*8-1:0]   line_data_i,
    input  logic [LINE_BYTES-1:0]     line_wr_i,
    input  logic [LINE_BYTES-1:0]     line_bad_i,
    input  logic [LINE_BYTES*8-1:0]   l1_data_i,
    output logic [LINE_BYTES*8-1:0]   data_o,
    output logic [LINE_BYTES-1:0]     bad_o
);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic own;
        assign own            = hit_i && line_wr_i[b];
        assign data_o[b*8+:8] = own ? line_data_i[b*8+:8] : l1_data_i[b*8+:8];
        assign bad_o[b]       = own && line_bad_i[b];
    end
endmodule

// File: rtl/rsc_store_cache.sv
module rsc_store_cache
    import rsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     flush_i,
    input  logic                     st_valid_i,
    input  logic [ADDR_W-1:0]        st_addr_i,
    input  logic [LINE_BYTES*8-1:0]  st_data_i,
    input  logic [LINE_BYTES-1:0]    st_be_i,
    input  logic                     st_addr_ok_i,
    input  logic                     st_data_ok_i,
    input  logic                     ld_valid_i,
    input  logic [ADDR_W-1:0]        ld_addr_i,
    input  logic [LINE_BYTES*8-1:0]  l1_data_i,
    output logic                     ld_hit_o,
    output logic [LINE_BYTES*8-1:0]  ld_data_o,
    output logic [LINE_BYTES-1:0]    ld_bad_o
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int DATA_W = LINE_BYTES * 8;

    typedef struct packed {
        logic                   vld;
        logic [TAG_W-1:0]       tag;
        logic [LINE_BYTES-1:0]  wr;
        logic [LINE_BYTES-1:0]  bad;
        logic [DATA_W-1:0]      data;
    } line_t;

    typedef struct packed {
        line_t [SETS-1:0][WAYS-1:0] ln;
        logic  [SETS-1:0]           lru;      // way to evict next
        logic                       rsp_hit;
        logic  [DATA_W-1:0]         rsp_data;
        logic  [LINE_BYTES-1:0]     rsp_bad;
    } state_t;

    state_t state_q, state_d, mid;

    logic [IDX_W-1:0] st_idx, ld_idx;
    logic [TAG_W-1:0] st_tag, ld_tag;
    assign st_idx = st_addr_i[OFF_W +: IDX_W];
    assign st_tag = st_addr_i[ADDR_W-1 -: TAG_W];
    assign ld_idx = ld_addr_i[OFF_W +: IDX_W];
    assign ld_tag = ld_addr_i[ADDR_W-1 -: TAG_W];

    way_vec_t                   st_vld, ld_vld, st_hit_vec, ld_hit_vec;
    logic [WAYS-1:0][TAG_W-1:0] st_tags, ld_tags;
    logic                       st_hit, ld_hit;
    logic [WAY_W-1:0]           st_way, ld_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            st_vld[w]  = state_q.ln[st_idx][w].vld;
            st_tags[w] = state_q.ln[st_idx][w].tag;
            ld_vld[w]  = mid.ln[ld_idx][w].vld;
            ld_tags[w] = mid.ln[ld_idx][w].tag;
        end
    end

    rsc_tag_match #(.TAG_W(TAG_W)) u_st_match (
        .vld_i(st_vld), .tags_i(st_tags), .req_tag_i(st_tag),
        .hit_vec_o(st_hit_vec), .hit_o(st_hit), .hit_way_o(st_way)
    );

    // store stage: produces the post-store image the probe looks at
    always_comb begin
        line_t            ln;
        logic [WAY_W-1:0] way;
        mid = state_q;
        ln  = '0;
        way = '0;
        if (st_valid_i && st_addr_ok_i) begin
            if (st_hit)             way = st_way;
            else if (!(&st_vld))    way = pick_free(st_vld);
            else                    way = WAY_W'(state_q.lru[st_idx]);
            ln = state_q.ln[st_idx][way];
            if (!st_hit) begin
                ln.vld = 1'b1;
                ln.tag = st_tag;
                ln.wr  = '0;
                ln.bad = '0;
            end
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (st_be_i[b]) begin
                    ln.data[b*8 +: 8] = st_data_i[b*8 +: 8];
                    ln.wr[b]          = 1'b1;
                    ln.bad[b]         = !st_data_ok_i;
                end
            end
            mid.ln[st_idx][way] = ln;
            mid.lru[st_idx]     = (way == '0);
        end
    end

    rsc_tag_match #(.TAG_W(TAG_W)) u_ld_match (
        .vld_i(ld_vld), .tags_i(ld_tags), .req_tag_i(ld_tag),
        .hit_vec_o(ld_hit_vec), .hit_o(ld_hit), .hit_way_o(ld_way)
    );

    line_t                 ld_line;
    logic [DATA_W-1:0]     mrg_data;
    logic [LINE_BYTES-1:0] mrg_bad;
    assign ld_line = mid.ln[ld_idx][ld_way];

    rsc_byte_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
        .hit_i(ld_hit), .line_data_i(ld_line.data), .line_wr_i(ld_line.wr),
        .line_bad_i(ld_line.bad), .l1_data_i(l1_data_i),
        .data_o(mrg_data), .bad_o(mrg_bad)
    );

    // probe, recency and flush stage
    always_comb begin
        state_d          = mid;
        state_d.rsp_hit  = 1'b0;
        state_d.rsp_data = '0;
        state_d.rsp_bad  = '0;
        if (ld_valid_i) begin
            state_d.rsp_hit  = ld_hit;
            state_d.rsp_data = mrg_data;
            state_d.rsp_bad  = mrg_bad;
            if (ld_hit) state_d.lru[ld_idx] = (ld_way == '0);
        end
        if (flush_i) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    state_d.ln[s][w].vld = 1'b0;
                end
            end
            state_d.lru = '0;
            if (ld_valid_i) begin
                state_d.rsp_hit  = 1'b0;
                state_d.rsp_data = l1_data_i;
                state_d.rsp_bad  = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign ld_hit_o  = state_q.rsp_hit;
    assign ld_data_o = state_q.rsp_data;
    assign ld_bad_o  = state_q.rsp_bad;

    // occupancy map, used by the checks below
    logic [SETS*WAYS-1:0] vld_map;
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_map[s*WAYS + w] = state_q.ln[s][w].vld;
            end
        end
    end

    a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (vld_map == '0));
    a_r8_flush_probe_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !ld_hit_o);
    a_r3_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_hit_o |-> (ld_bad_o == '0));
    a_r1_hit_needs_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_hit_o |-> $past(ld_valid_i));
    a_r4_drop_unknown_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_valid_i && !st_addr_ok_i && !flush_i) |=> $stable(vld_map));
    a_r6_single_way_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ld_hit_vec));
    a_r6_single_way_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(st_hit_vec));
endmodule

// File: tb/rsc_store_cache_tb_top.sv
`timescale 1ns/1ps
module rsc_store_cache_tb_top;
    localparam int ADDR_W = 32;
    localparam int LB     = 8;
    localparam int DW     = LB * 8;
    localparam logic [DW-1:0] L1 = 64'hA0A1_A2A3_A4A5_A6A7;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst_n, flush, st_valid, st_aok, st_dok, ld_valid;
    logic [ADDR_W-1:0] st_addr, ld_addr;
    logic [DW-1:0] st_data, l1_data, ld_data;
    logic [LB-1:0] st_be, ld_bad;
    logic          ld_hit;

    rsc_store_cache #(.ADDR_W(ADDR_W), .SETS(4), .LINE_BYTES(LB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
        .st_be_i(st_be), .st_addr_ok_i(st_aok), .st_data_ok_i(st_dok),
        .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .l1_data_i(l1_data),
        .ld_hit_o(ld_hit), .ld_data_o(ld_data), .ld_bad_o(ld_bad)
    );

    // op: 1 store, 2 probe, 3 store and probe of the same address
    typedef struct packed {
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [LB-1:0]     be;
        logic              aok;
        logic              dok;
        logic              e_hit;
        logic [DW-1:0]     e_data;
        logic [LB-1:0]     e_bad;
        logic [7:0]        req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 32'h000, 64'h0, 8'h00, 1'b1, 1'b1, 1'b0, L1, 8'h00, 8'd3},                         // R3 empty miss
        '{2'd1, 32'h000, 64'h1111_2222_3333_4444, 8'h0F, 1'b1, 1'b1, 1'b0, 64'h0, 8'h00, 8'd1},   // R1 store low half
        '{2'd2, 32'h000, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'hA0A1_A2A3_3333_4444, 8'h00, 8'd2},  // R2 merge
        '{2'd1, 32'h020, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b1, 1'b0, 64'h0, 8'h00, 8'd4},   // R4 dropped
        '{2'd2, 32'h020, 64'h0, 8'h00, 1'b1, 1'b1, 1'b0, L1, 8'h00, 8'd4},                        // R4 still miss
        '{2'd1, 32'h020, 64'h5555_5555_5555_5555, 8'hFF, 1'b1, 1'b0, 1'b0, 64'h0, 8'h00, 8'd5},   // R5 poisoned store
        '{2'd2, 32'h020, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'h5555_5555_5555_5555, 8'hFF, 8'd5},  // R5 all bad
        '{2'd1, 32'h020, 64'h6666_6666_6666_6666, 8'h03, 1'b1, 1'b1, 1'b0, 64'h0, 8'h00, 8'd5},   // R5 repair two bytes
        '{2'd2, 32'h020, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'h5555_5555_5555_6666, 8'hFC, 8'd5},  // R5 partial
        '{2'd2, 32'h000, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'hA0A1_A2A3_3333_4444, 8'h00, 8'd7},  // R7 refresh way 0
        '{2'd1, 32'h040, 64'h7777_7777_7777_7777, 8'hFF, 1'b1, 1'b1, 1'b0, 64'h0, 8'h00, 8'd6},   // R6 evicts 0x020
        '{2'd2, 32'h020, 64'h0, 8'h00, 1'b1, 1'b1, 1'b0, L1, 8'h00, 8'd6},                        // R6 evicted line lost
        '{2'd2, 32'h000, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'hA0A1_A2A3_3333_4444, 8'h00, 8'd7},  // R7 kept
        '{2'd3, 32'h008, 64'h8888_8888_8888_8888, 8'hF0, 1'b1, 1'b1, 1'b1, 64'h8888_8888_A4A5_A6A7, 8'h00, 8'd9}, // R9
        '{2'd2, 32'h040, 64'h0, 8'h00, 1'b1, 1'b1, 1'b1, 64'h7777_7777_7777_7777, 8'h00, 8'd1}   // R1 new line
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic idle();
        flush = 1'b0; st_valid = 1'b0; ld_valid = 1'b0;
        st_aok = 1'b0; st_dok = 1'b0; st_be = '0; st_data = '0;
        st_addr = '0; ld_addr = '0; l1_data = L1;
    endtask

    task automatic check(input logic e_hit, input logic [DW-1:0] e_data,
                         input logic [LB-1:0] e_bad, input string tag);
        n_chk++;
        if (ld_hit !== e_hit || ld_data !== e_data || ld_bad !== e_bad) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b data=%h bad=%h, expected hit=%0b data=%h bad=%h",
                     tag, ld_hit, ld_data, ld_bad, e_hit, e_data, e_bad);
        end
    endtask

    // one cycle: drive at the falling edge, sample 1 ns after the rising edge
    task automatic cycle(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [DW-1:0] data, input logic [LB-1:0] be,
                         input logic aok, input logic dok, input logic fl);
        @(negedge clk);
        st_valid = op[0]; ld_valid = op[1];
        st_addr = addr; ld_addr = addr; st_data = data; st_be = be;
        st_aok = aok; st_dok = dok; flush = fl; l1_data = L1;
        @(posedge clk);
        #1;
        idle();
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, '0, '0, "R10 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].be,
                  VECS[i].aok, VECS[i].dok, 1'b0);
            if (VECS[i].op[1])
                check(VECS[i].e_hit, VECS[i].e_data, VECS[i].e_bad,
                      $sformatf("R%0d vector %0d", VECS[i].req, i));
            else
                check(1'b0, '0, '0, $sformatf("R3 idle outputs after vector %0d", i));
        end

        // R8: flush together with a probe of a resident line
        cycle(2'd2, 32'h000, '0, '0, 1'b1, 1'b1, 1'b1);
        check(1'b0, L1, 8'h00, "R8 probe in flush cycle");
        cycle(2'd2, 32'h040, '0, '0, 1'b1, 1'b1, 1'b0);
        check(1'b0, L1, 8'h00, "R8 line gone after flush");
        cycle(2'd2, 32'h008, '0, '0, 1'b1, 1'b1, 1'b0);
        check(1'b0, L1, 8'h00, "R8 other set gone after flush");
        // R8: flush beats a store in the same cycle
        cycle(2'd1, 32'h000, 64'h9999_9999_9999_9999, 8'hFF, 1'b1, 1'b1, 1'b1);
        cycle(2'd2, 32'h000, '0, '0, 1'b1, 1'b1, 1'b0);
        check(1'b0, L1, 8'h00, "R8 store in flush cycle discarded");
        // R10: reset empties lines
        cycle(2'd1, 32'h000, 64'h1234_5678_9ABC_DEF0, 8'hFF, 1'b1, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cycle(2'd2, 32'h000, '0, '0, 1'b1, 1'b1, 1'b0);
        check(1'b0, L1, 8'h00, "R10 reset empties lines");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule